// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Hand-Over Control

This block compares a divided RF pulse train against a divided reference pulse train and drives UP and DN charge-pump commands. Both inputs are sampled in one oversampling clock domain through two-stage synchronizers, and their rising edges feed a two-flip-flop detector. A polarity bit lets the loop designer reverse the control direction. It does so by exchanging the two inputs ahead of the detector, and it exchanges the two monitor outputs in the same way.

A two-bit mode field decides two things: whether the detector is allowed to act, and whether synchronized copies of the two divided signals appear on the monitor outputs. In one mode the internal detector pulls the loop in and then steps aside when lock is declared, so that an external detector driven from the monitor outputs can take over. If lock is lost, the internal detector comes back. A digital lock detector declares lock only after a programmable number of consecutive reference cycles in which the two edges fell within one sample clock of each other. This keeps brief chance coincidences during acquisition from being reported as lock.

Top module: `pfd_ctrl`

## Requirements
- R1: With `sense`=1, when the RF rising edge trails the reference rising edge by L clocks, `up` is high for L+1 clocks and `dn` for one clock. The final clock is the overlap. `up` rises on the third clock edge after the reference edge is first sampled.
- R2: With `sense`=0, the same stimulus gives `dn` high for L+1 clocks and `up` for one clock.
- R3: When `up` and `dn` are both high, both are low on the next clock. With edges arriving in the same clock, each is high for exactly one clock.
- R4: In mode 2'b00 the detector operates and `mon_ref` and `mon_rf` stay low.
- R5: In modes 2'b01, 2'b10 and 2'b11, `mon_ref` follows the synchronized reference input and `mon_rf` follows the synchronized RF input when `sense`=1. The two are exchanged when `sense`=0.
- R6: In mode 2'b11, `up` and `dn` stay low whatever the inputs do.
- R7: In mode 2'b10, `up` and `dn` stay low while `locked` is high. Once `locked` falls, the detector responds to edges again.
- R8: `locked` rises when the Nth consecutive reference edge is judged coincident, where N is `lock_qual`. An edge is coincident when an RF rising edge is seen in the same clock, the clock before, or the clock after.
- R9: A reference edge with no RF edge within one clock clears `locked` and the consecutive count immediately.
- R10: `lock_qual`=0 selects the default count QUAL_DEF (16).
- R11: While `rst` is high and after it is released with idle inputs, `up`, `dn`, `mon_ref`, `mon_rf` and `locked` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rf_in | input | 1 | Divided RF pulse train |
| ref_in | input | 1 | Divided reference pulse train |
| sense | input | 1 | Polarity: 1 means an RF lag produces UP |
| mode | input | 2 | 00 run/monitors off, 01 run/monitors on, 10 hand over on lock, 11 detector off |
| lock_qual | input | QW | Consecutive coincident cycles needed for lock (0 = QUAL_DEF) |
| up | output | 1 | Charge-pump source command |
| dn | output | 1 | Charge-pump sink command |
| mon_ref | output | 1 | Monitor copy of the reference side |
| mon_rf | output | 1 | Monitor copy of the RF side |
| locked | output | 1 | Lock indication |

## Verification
The detector is driven with an RF edge trailing by three clocks, first under each polarity. Swapped widths of UP and DN then show that the input exchange really happens. Pulses of different widths on the two inputs show whether the monitor outputs were exchanged along with the inputs. Simultaneous edges separate a proper one-clock overlap from a stuck output. The lock detector is tried with edges one clock apart in both orders, which must qualify, and with two- and three-clock gaps, which must not. Long aligned runs locate the exact cycle count at which `locked` rises, both for the default count and for a programmed one. A lock-then-slip sequence in the hand-over mode shows the detector going quiet while locked and coming back after the slip.

// File: rtl/pfd_ctrl.sv
module pfd_ctrl #(
  parameter int QW       = 8,
  parameter int QUAL_DEF = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rf_in,
  input  logic          ref_in,
  input  logic          sense,
  input  logic [1:0]    mode,
  input  logic [QW-1:0] lock_qual,
  output logic          up,
  output logic          dn,
  output logic          mon_ref,
  output logic          mon_rf,
  output logic          locked
);
  localparam logic [QW-1:0] QDEF = QW'(QUAL_DEF);
  localparam logic [QW-1:0] QMAX = '1;

  logic [2:0] rf_sh, ref_sh;
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_sh  <= '0;
      ref_sh <= '0;
    end else begin
      rf_sh  <= {rf_sh[1:0], rf_in};
      ref_sh <= {ref_sh[1:0], ref_in};
    end
  end

  logic rf_lvl, ref_lvl, rf_rise, ref_rise;
  assign rf_lvl   = rf_sh[1];
  assign ref_lvl  = ref_sh[1];
  assign rf_rise  = rf_sh[1] & ~rf_sh[2];
  assign ref_rise = ref_sh[1] & ~ref_sh[2];

  logic mon_en;
  assign mon_en  = (mode != 2'b00);
  assign mon_ref = mon_en & (sense ? ref_lvl : rf_lvl);
  assign mon_rf  = mon_en & (sense ? rf_lvl : ref_lvl);

  logic set_up, set_dn, det_en;
  assign set_up = sense ? ref_rise : rf_rise;
  assign set_dn = sense ? rf_rise : ref_rise;
  assign det_en = (mode == 2'b11) ? 1'b0 :
                  (mode == 2'b10) ? ~locked : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !det_en) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (up && dn) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up | set_up;
      dn <= dn | set_dn;
    end
  end

  logic          rf_rise_q, ref_pend, good, bad;
  logic [QW-1:0] cnt, cnt_inc, qual_eff;

  assign qual_eff = (lock_qual == '0) ? QDEF : lock_qual;
  assign cnt_inc  = (cnt == QMAX) ? cnt : cnt + 1'b1;

  always_comb begin
    good = 1'b0;
    bad  = 1'b0;
    if (ref_rise) begin
      good = rf_rise | rf_rise_q;
    end else if (ref_pend) begin
      good = rf_rise;
      bad  = ~rf_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_rise_q <= 1'b0;
      ref_pend  <= 1'b0;
      cnt       <= '0;
      locked    <= 1'b0;
    end else begin
      rf_rise_q <= rf_rise;
      ref_pend  <= ref_rise & ~(rf_rise | rf_rise_q);
      if (good) begin
        cnt    <= cnt_inc;
        locked <= (cnt_inc >= qual_eff);
      end else if (bad) begin
        cnt    <= '0;
        locked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfd_ctrl_chk.sv
module pfd_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       up,
  input logic       dn,
  input logic       mon_ref,
  input logic       mon_rf,
  input logic       locked
);
  // R3
  overlap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |=> (!up && !dn));

  // R6
  detector_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (!up && !dn));

  // R4
  monitor_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |-> (!mon_ref && !mon_rf));

  // R7
  handover_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && locked) |=> (!up && !dn));
endmodule

bind pfd_ctrl pfd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .up(up), .dn(dn),
  .mon_ref(mon_ref), .mon_rf(mon_rf), .locked(locked)
);

// File: tb/sim_pfd_ctrl.sv
`timescale 1ns/1ps
module sim_pfd_ctrl;
  logic       clk = 1'b0, rst = 1'b1;
  logic       rf_in = 1'b0, ref_in = 1'b0, sense = 1'b1;
  logic [1:0] mode = 2'b01;
  logic [7:0] lock_qual = 8'd4;
  logic       up, dn, mon_ref, mon_rf, locked;
  int n_chk = 0, n_bad = 0;
  int up_n, dn_n, mr_n, mf_n;
  bit done = 0;

  always #5 clk = ~clk;

  pfd_ctrl u0 (
    .clk(clk), .rst(rst), .rf_in(rf_in), .ref_in(ref_in), .sense(sense),
    .mode(mode), .lock_qual(lock_qual), .up(up), .dn(dn),
    .mon_ref(mon_ref), .mon_rf(mon_rf), .locked(locked)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(logic s, logic [1:0] m, logic [7:0] q);
    @(negedge clk);
    rst = 1'b1; sense = s; mode = m; lock_qual = q;
    rf_in = 1'b0; ref_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clr();
    up_n = 0; dn_n = 0; mr_n = 0; mf_n = 0;
  endtask

  task automatic period(int ro, int rw, int fo, int fw);
    for (int i = 0; i < 20; i++) begin
      ref_in = (i >= ro) && (i < ro + rw);
      rf_in  = (i >= fo) && (i < fo + fw);
      @(negedge clk);
      up_n += up; dn_n += dn; mr_n += mon_ref; mf_n += mon_rf;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 up in reset", up, 0);
    chk("R11 locked in reset", locked, 0);
    restart(1'b1, 2'b01, 8'd4);
    chk("R11 outputs idle", {up, dn, mon_ref, mon_rf, locked}, 0);
  endtask

  task automatic t_sense_hi();
    restart(1'b1, 2'b01, 8'd4);
    clr(); period(0, 10, 3, 5);
    chk("R1 up width", up_n, 4);
    chk("R1 dn width", dn_n, 1);
    chk("R5 mon_ref sense1", mr_n, 10);
    chk("R5 mon_rf sense1", mf_n, 5);
  endtask

  task automatic t_sense_lo();
    restart(1'b0, 2'b01, 8'd4);
    clr(); period(0, 10, 3, 5);
    chk("R2 dn width", dn_n, 4);
    chk("R2 up width", up_n, 1);
    chk("R5 mon_ref sense0", mr_n, 5);
    chk("R5 mon_rf sense0", mf_n, 10);
  endtask

  task automatic t_aligned();
    restart(1'b1, 2'b01, 8'd4);
    clr(); period(0, 10, 0, 10);
    chk("R3 up one clock", up_n, 1);
    chk("R3 dn one clock", dn_n, 1);
  endtask

  task automatic t_mon_off();
    restart(1'b1, 2'b00, 8'd4);
    clr(); period(0, 10, 3, 5);
    chk("R4 mon_ref off", mr_n, 0);
    chk("R4 mon_rf off", mf_n, 0);
    chk("R4 detector runs", up_n, 4);
  endtask

  task automatic t_disabled();
    restart(1'b1, 2'b11, 8'd4);
    clr(); period(0, 10, 3, 5);
    chk("R6 up held", up_n, 0);
    chk("R6 dn held", dn_n, 0);
    chk("R5 mon active mode11", mr_n, 10);
  endtask

  task automatic t_lock();
    restart(1'b1, 2'b01, 8'd4);
    repeat (3) period(0, 10, 1, 10);
    chk("R8 not yet locked", locked, 0);
    period(0, 10, 1, 10);
    chk("R8 locked rf lags 1", locked, 1);
    period(0, 10, 2, 10);
    chk("R9 gap 2 clears", locked, 0);
    repeat (3) period(1, 10, 0, 10);
    chk("R8 rf leads 1 not yet", locked, 0);
    period(1, 10, 0, 10);
    chk("R8 locked rf leads 1", locked, 1);
  endtask

  task automatic t_default();
    restart(1'b1, 2'b01, 8'd0);
    repeat (15) period(0, 10, 0, 10);
    chk("R10 15 cycles", locked, 0);
    period(0, 10, 0, 10);
    chk("R10 16 cycles", locked, 1);
  endtask

  task automatic t_handover();
    restart(1'b1, 2'b10, 8'd4);
    repeat (4) period(0, 10, 0, 10);
    chk("R7 locked", locked, 1);
    clr(); period(0, 10, 0, 10);
    chk("R7 quiet while locked", up_n + dn_n, 0);
    clr(); period(0, 10, 3, 10);
    chk("R9 slip clears lock", locked, 0);
    chk("R7 detector back", (dn_n > 0) ? 1 : 0, 1);
  endtask

  initial begin
    t_reset();
    t_sense_hi();
    t_sense_lo();
    t_aligned();
    t_mon_off();
    t_disabled();
    t_lock();
    t_default();
    t_handover();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule